// File: doc/BRIEF.md
# RTC Dual Alarm Interrupt Controller

This block produces the interrupt outputs of a real-time clock. It compares the current weekday, hour and minute, which come from external time counters, against two alarm presets. The weekly alarm checks weekday, hour and minute. The daily alarm checks hour and minute only. A third source is a periodic tick from an external divider. A 3-bit select turns the tick on and chooses between level mode and pulse mode.

Software works through a small register file. It holds the alarm presets, an enable register and a status register. A flag in the status register is cleared by writing 0 to it. Writing 1 to a flag does nothing, and clearing a flag never touches its enable. The weekly alarm drives pin B. Pin A carries the active-low OR of the daily alarm and the periodic interrupt.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The weekly flag (status bit 1) sets when all of these hold: the enable is 1, the hour and minute equal the weekly presets, and bit d of the weekday mask is set for the current weekday d (0..6). While that flag is set and enabled, irq_b_no is low.
- R2: The daily flag (status bit 0) sets when the enable is 1 and the hour and minute equal the daily presets. The weekday is ignored. While the daily flag is set and enabled, irq_a_no is low.
- R3: An alarm flag sets only on the cycle after the time first starts to match. A flag cleared while the time still matches stays clear until the time leaves the match and comes back into it.
- R4: An alarm flag cannot set while its enable is 0. Each pin contribution is flag AND enable, so writing an enable to 0 releases the pin on the next cycle and leaves the flag set.
- R5: The enable register at address 0xE has the weekly enable in bit 7, the daily enable in bit 6 and the periodic select in bits 2..0. The other bits read as 0.
- R6: The status register at address 0xF has the daily flag in bit 0, the weekly flag in bit 1 and the periodic flag in bit 2. Writing 0 to a bit clears that flag. Writing 1 has no effect. A new set in the same cycle wins over a clear. A status write leaves the enable register unchanged, so the alarm fires again at its next match.
- R7: A periodic select of 000 disables the tick: the periodic flag does not set and irq_a_no stays high.
- R8: A select of 100 to 111 is level mode. A tick sets the periodic flag, and irq_a_no stays low until that flag is cleared.
- R9: A select of 001 to 011 is pulse mode. irq_a_no is low for exactly the one cycle after each tick. The periodic flag still sets but does not hold the pin.
- R10: irq_a_no is low while either the daily alarm or the periodic interrupt asserts. It is high only when neither one asserts.
- R11: After reset, all presets, enables, select and flags are 0 and both pins are high.
- R12: The presets are read/write at these addresses: weekly minute 0x8, weekly hour 0x9, weekly weekday mask 0xA (bits 6..0), daily minute 0xB, daily hour 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_dow_i | input | 3 | Current weekday, 0..6 |
| cur_hour_i | input | 5 | Current hour, binary |
| cur_min_i | input | 6 | Current minute, binary |
| tick_i | input | 1 | Periodic tick, one-cycle pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_a_no | output | 1 | Daily or periodic interrupt, active low |
| irq_b_no | output | 1 | Weekly interrupt, active low |

## Verification
The assertions assume three things about the inputs. The time inputs change at most once per cycle and hold a weekday of 0 to 6. The tick is a single-cycle pulse. Register writes are single-cycle strobes. The stimulus meets these by changing time, tick and bus signals only on falling edges. It raises the tick for one cycle at a time and drops the write strobe after each access. It also moves the time away from a preset before moving it back, so that each alarm event comes from a real entry into the match.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOW_N  = 7;
  localparam int DOW_W  = $clog2(DOW_N);
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_WMIN  = 4'h8;
  localparam logic [ADDR_W-1:0] ADR_WHOUR = 4'h9;
  localparam logic [ADDR_W-1:0] ADR_WDAY  = 4'hA;
  localparam logic [ADDR_W-1:0] ADR_DMIN  = 4'hB;
  localparam logic [ADDR_W-1:0] ADR_DHOUR = 4'hC;
  localparam logic [ADDR_W-1:0] ADR_CR1   = 4'hE;
  localparam logic [ADDR_W-1:0] ADR_CR2   = 4'hF;

  localparam int CR1_WEN = 7;
  localparam int CR1_DEN = 6;
  localparam int ST_DAY  = 0;
  localparam int ST_WEEK = 1;
  localparam int ST_PER  = 2;
endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [MIN_W-1:0]  wk_min_o,
  output logic [HOUR_W-1:0] wk_hour_o,
  output logic [DOW_N-1:0]  wk_dmask_o,
  output logic [MIN_W-1:0]  dy_min_o,
  output logic [HOUR_W-1:0] dy_hour_o,
  output logic              wk_en_o,
  output logic              dy_en_o,
  output logic [SEL_W-1:0]  per_sel_o
);
  logic [MIN_W-1:0]  wk_min_q, dy_min_q;
  logic [HOUR_W-1:0] wk_hour_q, dy_hour_q;
  logic [DOW_N-1:0]  wk_dmask_q;
  logic              wk_en_q, dy_en_q;
  logic [SEL_W-1:0]  per_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wk_min_q   <= '0;
      wk_hour_q  <= '0;
      wk_dmask_q <= '0;
      dy_min_q   <= '0;
      dy_hour_q  <= '0;
      wk_en_q    <= 1'b0;
      dy_en_q    <= 1'b0;
      per_sel_q  <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADR_WMIN:  wk_min_q   <= wdata_i[MIN_W-1:0];
        ADR_WHOUR: wk_hour_q  <= wdata_i[HOUR_W-1:0];
        ADR_WDAY:  wk_dmask_q <= wdata_i[DOW_N-1:0];
        ADR_DMIN:  dy_min_q   <= wdata_i[MIN_W-1:0];
        ADR_DHOUR: dy_hour_q  <= wdata_i[HOUR_W-1:0];
        ADR_CR1: begin
          wk_en_q   <= wdata_i[CR1_WEN];
          dy_en_q   <= wdata_i[CR1_DEN];
          per_sel_q <= wdata_i[SEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  assign wk_min_o   = wk_min_q;
  assign wk_hour_o  = wk_hour_q;
  assign wk_dmask_o = wk_dmask_q;
  assign dy_min_o   = dy_min_q;
  assign dy_hour_o  = dy_hour_q;
  assign wk_en_o    = wk_en_q;
  assign dy_en_o    = dy_en_q;
  assign per_sel_o  = per_sel_q;

  // R6
  cr2_keeps_cr1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_CR2) |=> $stable({wk_en_q, dy_en_q, per_sel_q}));
  // R5
  cr1_wen_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADR_CR1) |=> (wk_en_q == $past(wdata_i[CR1_WEN])));
endmodule

// File: rtl/rtc_alarm_chan.sv
`timescale 1ns/1ps
module rtc_alarm_chan
  import rtc_alarm_pkg::*;
#(
  parameter bit USE_DOW = 1'b1
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DOW_W-1:0]  cur_dow_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] set_hour_i,
  input  logic [MIN_W-1:0]  set_min_i,
  input  logic [DOW_N-1:0]  set_dmask_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic day_ok, hit, hit_q, flag_q, set_ev;

  generate
    if (USE_DOW) begin : g_dow
      logic [DOW_N-1:0] day_hot;
      for (genvar i = 0; i < DOW_N; i++) begin : g_day
        assign day_hot[i] = (cur_dow_i == DOW_W'(i));
      end
      assign day_ok = |(day_hot & set_dmask_i);
    end else begin : g_nodow
      logic unused_day;
      assign unused_day = ^{cur_dow_i, set_dmask_i};
      assign day_ok = 1'b1;
    end
  endgenerate

  assign hit    = day_ok && (cur_hour_i == set_hour_i) && (cur_min_i == set_min_i);
  assign set_ev = hit && !hit_q && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (set_ev)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R4
  set_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(en_i));
  // R3
  set_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit));
  // R6
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);
  // R4
  dis_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
module rtc_periodic
  import rtc_alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic on, level, flag_q, pulse_q;

  assign on    = |sel_i;
  assign level = sel_i[SEL_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && on && !level;
      if (tick_i && on) flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = on & (level ? flag_q : pulse_q);

  // R7
  per_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(tick_i) && ($past(sel_i) != '0)));
  // R9
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !level && !tick_i) |=> (!irq_o || sel_i[SEL_W-1]));
  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level && flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DOW_W-1:0]  cur_dow_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_a_no,
  output logic              irq_b_no
);
  logic [MIN_W-1:0]  wk_min, dy_min;
  logic [HOUR_W-1:0] wk_hour, dy_hour;
  logic [DOW_N-1:0]  wk_dmask;
  logic              wk_en, dy_en;
  logic [SEL_W-1:0]  per_sel;
  logic              st_wr;
  logic              wk_flag, dy_flag, per_flag;
  logic              wk_irq, dy_irq, per_irq;

  assign st_wr = reg_wr_i && (reg_addr_i == ADR_CR2);

  rtc_alarm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .wk_min_o   (wk_min),
    .wk_hour_o  (wk_hour),
    .wk_dmask_o (wk_dmask),
    .dy_min_o   (dy_min),
    .dy_hour_o  (dy_hour),
    .wk_en_o    (wk_en),
    .dy_en_o    (dy_en),
    .per_sel_o  (per_sel)
  );

  rtc_alarm_chan #(.USE_DOW(1'b1)) u_week (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_dow_i   (cur_dow_i),
    .cur_hour_i  (cur_hour_i),
    .cur_min_i   (cur_min_i),
    .set_hour_i  (wk_hour),
    .set_min_i   (wk_min),
    .set_dmask_i (wk_dmask),
    .en_i        (wk_en),
    .clr_i       (st_wr && !reg_wdata_i[ST_WEEK]),
    .flag_o      (wk_flag),
    .irq_o       (wk_irq)
  );

  rtc_alarm_chan #(.USE_DOW(1'b0)) u_day (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_dow_i   (cur_dow_i),
    .cur_hour_i  (cur_hour_i),
    .cur_min_i   (cur_min_i),
    .set_hour_i  (dy_hour),
    .set_min_i   (dy_min),
    .set_dmask_i ({DOW_N{1'b1}}),
    .en_i        (dy_en),
    .clr_i       (st_wr && !reg_wdata_i[ST_DAY]),
    .flag_o      (dy_flag),
    .irq_o       (dy_irq)
  );

  rtc_periodic u_per (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .sel_i  (per_sel),
    .clr_i  (st_wr && !reg_wdata_i[ST_PER]),
    .flag_o (per_flag),
    .irq_o  (per_irq)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADR_WMIN:  reg_rdata_o = DATA_W'(wk_min);
      ADR_WHOUR: reg_rdata_o = DATA_W'(wk_hour);
      ADR_WDAY:  reg_rdata_o = DATA_W'(wk_dmask);
      ADR_DMIN:  reg_rdata_o = DATA_W'(dy_min);
      ADR_DHOUR: reg_rdata_o = DATA_W'(dy_hour);
      ADR_CR1: begin
        reg_rdata_o[CR1_WEN]     = wk_en;
        reg_rdata_o[CR1_DEN]     = dy_en;
        reg_rdata_o[SEL_W-1:0]   = per_sel;
      end
      ADR_CR2: begin
        reg_rdata_o[ST_DAY]  = dy_flag;
        reg_rdata_o[ST_WEEK] = wk_flag;
        reg_rdata_o[ST_PER]  = per_flag;
      end
      default: ;
    endcase
  end

  assign irq_a_no = ~(dy_irq | per_irq);
  assign irq_b_no = ~wk_irq;

  // R1
  pin_b_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_b_no |-> (wk_en && wk_flag));
  // R10
  pin_a_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dy_irq || per_irq) |-> !irq_a_no);
  // R10
  pin_a_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dy_irq && !per_irq) |-> irq_a_no);
  // R7
  pin_a_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dy_en && per_sel == '0) |-> irq_a_no);
endmodule

// File: tb/rtc_alarm_irq_test.sv
`timescale 1ns/1ps
module rtc_alarm_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dow = 3'd6;
  logic [4:0] hour = 5'd23;
  logic [5:0] minute = 6'd59;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_a_n, irq_b_n;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rtc_alarm_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .cur_dow_i(dow), .cur_hour_i(hour),
    .cur_min_i(minute), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_a_no(irq_a_n), .irq_b_no(irq_b_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_time(input logic [2:0] d, input logic [4:0] h, input logic [5:0] m);
    @(negedge clk);
    dow = d; hour = h; minute = m;
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R11 pin A", irq_a_n, 1);
    check("R11 pin B", irq_b_n, 1);
    rreg(4'hE, v); check("R11 cr1", v, 8'h00);
    rreg(4'hF, v); check("R11 cr2", v, 8'h00);
    rreg(4'hA, v); check("R11 mask", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wreg(4'h8, 8'd30); wreg(4'h9, 8'd10); wreg(4'hA, 8'h14);
    wreg(4'hB, 8'd15); wreg(4'hC, 8'd7);
    rreg(4'h8, v); check("R12 wk min", v, 30);
    rreg(4'h9, v); check("R12 wk hour", v, 10);
    rreg(4'hA, v); check("R12 wk mask", v, 8'h14);
    rreg(4'hB, v); check("R12 dy min", v, 15);
    rreg(4'hC, v); check("R12 dy hour", v, 7);
    wreg(4'hE, 8'hFF);
    rreg(4'hE, v); check("R5 cr1 layout", v, 8'hC7);
    wreg(4'hE, 8'h00);
    rreg(4'hE, v); check("R5 cr1 zero", v, 8'h00);
  endtask

  task automatic t_weekly();
    logic [7:0] v;
    wreg(4'hE, 8'h80);
    set_time(3'd2, 5'd10, 6'd30);
    rreg(4'hF, v); check("R1 flag day2", v, 8'h02);
    check("R1 pin B low", irq_b_n, 0);
    check("R1 pin A high", irq_a_n, 1);
    wreg(4'hF, 8'hFD);
    check("R1 pin B released", irq_b_n, 1);
    set_time(3'd3, 5'd10, 6'd30);
    rreg(4'hF, v); check("R1 day3 not in mask", v, 8'h00);
    set_time(3'd4, 5'd10, 6'd30);
    rreg(4'hF, v); check("R1 flag day4", v, 8'h02);
    wreg(4'hF, 8'hFD);
    set_time(3'd4, 5'd10, 6'd31);
    wreg(4'hE, 8'h00);
  endtask

  task automatic t_daily();
    logic [7:0] v;
    wreg(4'hE, 8'h40);
    set_time(3'd5, 5'd7, 6'd15);
    rreg(4'hF, v); check("R2 daily flag", v, 8'h01);
    check("R2 pin A low", irq_a_n, 0);
    check("R2 pin B high", irq_b_n, 1);
    wreg(4'hF, 8'hFE);
    check("R2 pin A released", irq_a_n, 1);
    set_time(3'd5, 5'd7, 6'd16);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    set_time(3'd1, 5'd7, 6'd15);
    rreg(4'hF, v); check("R3 first entry", v, 8'h01);
    wreg(4'hF, 8'hFE);
    repeat (4) @(negedge clk);
    rreg(4'hF, v); check("R3 stays clear in minute", v, 8'h00);
    check("R3 pin A high in minute", irq_a_n, 1);
    set_time(3'd1, 5'd7, 6'd16);
    set_time(3'd1, 5'd7, 6'd15);
    rreg(4'hF, v); check("R3 re-entry sets", v, 8'h01);
    wreg(4'hF, 8'hFE);
    set_time(3'd1, 5'd7, 6'd16);
    wreg(4'hE, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    set_time(3'd1, 5'd7, 6'd15);
    rreg(4'hF, v); check("R4 no set when disabled", v, 8'h00);
    check("R4 pin A high when disabled", irq_a_n, 1);
    set_time(3'd1, 5'd7, 6'd16);
    wreg(4'hE, 8'h40);
    set_time(3'd1, 5'd7, 6'd15);
    check("R4 pin A low enabled", irq_a_n, 0);
    wreg(4'hE, 8'h00);
    check("R4 disable releases pin", irq_a_n, 1);
    rreg(4'hF, v); check("R4 flag kept", v, 8'h01);
    wreg(4'hF, 8'hFE);
    set_time(3'd1, 5'd7, 6'd16);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wreg(4'hE, 8'hC0);
    set_time(3'd2, 5'd10, 6'd30);
    rreg(4'hF, v); check("R6 weekly set", v, 8'h02);
    wreg(4'hF, 8'hFF);
    rreg(4'hF, v); check("R6 write 1 no effect", v, 8'h02);
    check("R6 pin B still low", irq_b_n, 0);
    wreg(4'hF, 8'hFD);
    rreg(4'hF, v); check("R6 write 0 clears", v, 8'h00);
    check("R6 pin B released", irq_b_n, 1);
    rreg(4'hE, v); check("R6 enables untouched", v, 8'hC0);
    set_time(3'd2, 5'd10, 6'd31);
    set_time(3'd2, 5'd10, 6'd30);
    check("R6 re-armed fires", irq_b_n, 0);
    wreg(4'hF, 8'hFD);
    set_time(3'd2, 5'd10, 6'd31);
    wreg(4'hE, 8'h00);
  endtask

  task automatic t_per_off();
    logic [7:0] v;
    pulse_tick();
    check("R7 pin A high sel 0", irq_a_n, 1);
    rreg(4'hF, v); check("R7 no flag sel 0", v, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] v;
    wreg(4'hE, 8'h04);
    pulse_tick();
    rreg(4'hF, v); check("R8 flag set", v, 8'h04);
    check("R8 pin A low", irq_a_n, 0);
    repeat (3) @(negedge clk);
    check("R8 pin A held", irq_a_n, 0);
    wreg(4'hF, 8'hFB);
    check("R8 clear releases", irq_a_n, 1);
    wreg(4'hE, 8'h00);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    wreg(4'hE, 8'h01);
    pulse_tick();
    check("R9 pulse low", irq_a_n, 0);
    rreg(4'hF, v); check("R9 flag set", v, 8'h04);
    @(negedge clk);
    check("R9 one cycle only", irq_a_n, 1);
    wreg(4'hF, 8'hFB);
    wreg(4'hE, 8'h00);
  endtask

  task automatic t_or();
    logic [7:0] v;
    wreg(4'hE, 8'h44);
    pulse_tick();
    check("R10 periodic alone", irq_a_n, 0);
    set_time(3'd0, 5'd7, 6'd15);
    rreg(4'hF, v); check("R10 both flags", v, 8'h05);
    wreg(4'hF, 8'hFB);
    check("R10 daily keeps low", irq_a_n, 0);
    wreg(4'hF, 8'hFE);
    check("R10 neither high", irq_a_n, 1);
    set_time(3'd0, 5'd7, 6'd16);
    wreg(4'hE, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_weekly();
    t_daily();
    t_edge();
    t_enable();
    t_clear();
    t_per_off();
    t_level();
    t_pulse();
    t_or();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule